// File: doc/BRIEF.md
# Byte-Wide Memory Block Transfer Engine

This engine copies blocks of words between a byte-wide external memory and the on-chip program or data memory. Software first sets a control word (direction, word format, wait-state count, core-restart option), an on-chip start address, and a 22-bit external byte location made of a 14-bit offset and an 8-bit page. It then writes a word count. A nonzero count starts the transfer.

The engine gathers bytes into on-chip words, or splits on-chip words into bytes. It runs each byte access on the external bus for a programmable number of cycles and gives way to processor accesses on that bus. Each finished word decrements the count, and software can read the count while the transfer runs. When the count reaches zero the engine pulses an interrupt. If the core-restart option is set, the processor core is held for the whole transfer and told to restart at address 0 at the end.

Top module: `bytedma_engine`

## Requirements
- R1: Register select codes are 0 for control, 1 for on-chip address, 2 for external byte offset, 3 for external page and 4 for word count. The control byte is laid out as {ctx[7], wait[6:3], fmt[2:1], dir[0]}. Every register reads back its current value through `cfg_rdata`, with unused upper bits as zero. After reset every register reads 0.
- R2: Writing a nonzero value to the count register while idle starts a transfer. Writing zero starts nothing, and the external bus and memory port stay quiet.
- R3: While a transfer runs, writes to any register are ignored.
- R4: Format 0 moves 24-bit words to or from program memory (`mem_pm`=1) as three bytes, most significant byte first.
- R5: Format 1 moves 16-bit words to or from data memory as two bytes, most significant byte first. Bits 23:16 of a written word are zero.
- R6: Format 2 moves one byte per data-memory word in bits 15:8. Format 3 moves one byte per data-memory word in bits 7:0. All other bits of a written word are zero.
- R7: The external address is {page, offset}. It rises by one per byte and carries from the offset into the page, wrapping from 0x3FFFFF to 0. The on-chip address rises by one per word. Both advanced values can be read back.
- R8: Each external byte access holds `ext_req` high, with a stable address, for exactly wait+1 cycles.
- R9: A new engine byte access begins only in the cycle after a cycle in which `cpu_ext_req` was low.
- R10: The count register drops by one as each word completes, and the new value is readable in the following cycle.
- R11: `irq` pulses for one cycle, after every word has moved and the count reads 0. The engine is idle in the next cycle.
- R12: With ctx=1, `core_hold` is high from the cycle after the starting write through the `irq` cycle, and `core_restart` pulses together with `irq`. With ctx=0, both stay low.
- R13: With dir=0, external bytes are read (`ext_we`=0) and words are written on-chip. With dir=1, on-chip words are read through a port whose read data is valid one cycle after `mem_en`, and their bytes are written out (`ext_we`=1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select for write and read |
| cfg_wdata | input | 14 | Register write data |
| cfg_rdata | output | 14 | Selected register value |
| ext_req | output | 1 | External byte access in progress |
| ext_we | output | 1 | External access is a write |
| ext_addr | output | 22 | External byte address {page, offset} |
| ext_wdata | output | 8 | Byte written to external memory |
| ext_rdata | input | 8 | Byte read from external memory |
| cpu_ext_req | input | 1 | Processor claims the external bus |
| mem_en | output | 1 | On-chip memory access strobe |
| mem_we | output | 1 | On-chip access is a write |
| mem_pm | output | 1 | Program memory (1) or data memory (0) |
| mem_addr | output | 14 | On-chip word address |
| mem_wdata | output | 24 | On-chip write word |
| mem_rdata | input | 24 | On-chip read word, valid one cycle after a read strobe |
| irq | output | 1 | Transfer-complete pulse |
| core_hold | output | 1 | Hold the processor core |
| core_restart | output | 1 | Restart the processor core at address 0 |

## Verification
Some properties are checked on every cycle: yielding to the processor before a byte access, the stable address through each wait-state run, zero fill of data-memory words, the single-cycle interrupt with the idle state after it, the restart pulse lying inside the hold, and a quiet bus and memory port when idle. Other behaviours need whole scenarios and are left to the bench. These are the byte order of each format, the page carry, the exact wait-state length, the live count value, and the fact that writes made during a transfer have no effect.

// File: rtl/bdma_pkg.sv
package bdma_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 24;

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_IADDR = 3'd1;
    localparam logic [2:0] RA_EOFS  = 3'd2;
    localparam logic [2:0] RA_PAGE  = 3'd3;
    localparam logic [2:0] RA_COUNT = 3'd4;

    typedef enum logic [1:0] {
        FMT_PM24  = 2'b00,
        FMT_DM16  = 2'b01,
        FMT_DM8HI = 2'b10,
        FMT_DM8LO = 2'b11
    } fmt_e;

    typedef struct packed {
        logic       ctx;
        logic [3:0] ws;
        fmt_e       fmt;
        logic       dir;
    } ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LATCH,
        ST_ARB,
        ST_BACC,
        ST_STORE,
        ST_DONE
    } st_e;

    function automatic logic [1:0] fmt_nbytes(fmt_e f);
        case (f)
            FMT_PM24: return 2'd3;
            FMT_DM16: return 2'd2;
            default:  return 2'd1;
        endcase
    endfunction

    // gathered bytes (newest in the low byte) -> on-chip word
    function automatic logic [WORD_W-1:0] fmt_pack(fmt_e f, logic [WORD_W-1:0] s);
        case (f)
            FMT_PM24:  return s;
            FMT_DM16:  return {8'h00, s[15:0]};
            FMT_DM8HI: return {8'h00, s[7:0], 8'h00};
            default:   return {16'h0000, s[7:0]};
        endcase
    endfunction

    // on-chip word -> shift register with the first byte to send on top
    function automatic logic [WORD_W-1:0] fmt_align(fmt_e f, logic [WORD_W-1:0] w);
        case (f)
            FMT_PM24:  return w;
            FMT_DM16:  return {w[15:0], 8'h00};
            FMT_DM8HI: return {w[15:8], 16'h0000};
            default:   return {w[7:0], 16'h0000};
        endcase
    endfunction

endpackage

// File: rtl/bdma_regs.sv
module bdma_regs
    import bdma_pkg::*;
#(
    parameter int IA_W  = 14,
    parameter int EA_W  = 14,
    parameter int PG_W  = 8,
    parameter int CNT_W = 14,
    parameter int CFG_W = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [2:0]           sel,
    input  logic [CFG_W-1:0]     wr_data,
    output logic [CFG_W-1:0]     rd_data,
    input  logic                 busy,
    input  logic                 word_step,
    input  logic                 byte_step,
    output ctrl_t                ctrl,
    output logic [IA_W-1:0]      iaddr,
    output logic [EA_W+PG_W-1:0] xaddr,
    output logic [CNT_W-1:0]     count,
    output logic                 start
);
    localparam int XA_W = EA_W + PG_W;

    logic wr_ok;
    assign wr_ok = wr_en && !busy;
    assign start = wr_ok && (sel == RA_COUNT) && (wr_data[CNT_W-1:0] != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            iaddr <= '0;
            xaddr <= '0;
            count <= '0;
        end else begin
            if (wr_ok) begin
                case (sel)
                    RA_CTRL:  ctrl <= ctrl_t'(wr_data[7:0]);
                    RA_IADDR: iaddr <= wr_data[IA_W-1:0];
                    RA_EOFS:  xaddr[EA_W-1:0] <= wr_data[EA_W-1:0];
                    RA_PAGE:  xaddr[XA_W-1:EA_W] <= wr_data[PG_W-1:0];
                    RA_COUNT: count <= wr_data[CNT_W-1:0];
                    default: ;
                endcase
            end
            if (word_step) begin
                count <= count - 1'b1;
                iaddr <= iaddr + 1'b1;
            end
            if (byte_step) begin
                xaddr <= xaddr + 1'b1;
            end
        end
    end

    always_comb begin
        case (sel)
            RA_CTRL:  rd_data = CFG_W'(ctrl);
            RA_IADDR: rd_data = CFG_W'(iaddr);
            RA_EOFS:  rd_data = CFG_W'(xaddr[EA_W-1:0]);
            RA_PAGE:  rd_data = CFG_W'(xaddr[XA_W-1:EA_W]);
            RA_COUNT: rd_data = CFG_W'(count);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/bdma_lane.sv
module bdma_lane
    import bdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fmt_e              fmt,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              push,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              pop,
    output logic [BYTE_W-1:0] byte_out,
    output logic [WORD_W-1:0] word_out
);
    logic [WORD_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= fmt_align(fmt, word_in);
        end else if (push) begin
            sreg <= {sreg[WORD_W-BYTE_W-1:0], byte_in};
        end else if (pop) begin
            sreg <= {sreg[WORD_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
        end
    end

    assign byte_out = sreg[WORD_W-1:WORD_W-BYTE_W];
    assign word_out = fmt_pack(fmt, sreg);

endmodule

// File: rtl/bdma_seq.sv
module bdma_seq
    import bdma_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] count,
    input  logic             cpu_ext_req,
    output logic             busy,
    output logic             ext_req,
    output logic             mem_en,
    output logic             mem_we,
    output logic             word_step,
    output logic             byte_step,
    output logic             lane_load,
    output logic             lane_push,
    output logic             lane_pop,
    output logic             irq
);
    st_e        st, st_n;
    logic [3:0] wcnt;
    logic [1:0] bidx;
    logic [1:0] nb;
    logic       last_b, last_w, done_b;

    assign nb     = fmt_nbytes(ctrl.fmt);
    assign last_b = (bidx == nb - 2'd1);
    assign last_w = (count == CNT_W'(1));
    assign done_b = (st == ST_BACC) && (wcnt == 4'd0);

    always_comb begin
        st_n = st;
        case (st)
            ST_IDLE:  if (start) st_n = ctrl.dir ? ST_LOAD : ST_ARB;
            ST_LOAD:  st_n = ST_LATCH;
            ST_LATCH: st_n = ST_ARB;
            ST_ARB:   if (!cpu_ext_req) st_n = ST_BACC;
            ST_BACC: begin
                if (done_b) begin
                    if (!last_b)       st_n = ST_ARB;
                    else if (!ctrl.dir) st_n = ST_STORE;
                    else if (last_w)   st_n = ST_DONE;
                    else               st_n = ST_LOAD;
                end
            end
            ST_STORE: st_n = last_w ? ST_DONE : ST_ARB;
            ST_DONE:  st_n = ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            wcnt <= '0;
            bidx <= '0;
        end else begin
            st <= st_n;
            if (st == ST_ARB && !cpu_ext_req) begin
                wcnt <= ctrl.ws;
            end else if (st == ST_BACC && wcnt != 4'd0) begin
                wcnt <= wcnt - 4'd1;
            end
            if (st == ST_IDLE) begin
                bidx <= '0;
            end else if (done_b) begin
                bidx <= last_b ? 2'd0 : bidx + 2'd1;
            end
        end
    end

    assign busy      = (st != ST_IDLE);
    assign ext_req   = (st == ST_BACC);
    assign mem_en    = (st == ST_LOAD) || (st == ST_STORE);
    assign mem_we    = (st == ST_STORE);
    assign byte_step = done_b;
    assign word_step = (st == ST_STORE) || (done_b && last_b && ctrl.dir);
    assign lane_load = (st == ST_LATCH);
    assign lane_push = done_b && !ctrl.dir;
    assign lane_pop  = done_b && ctrl.dir;
    assign irq       = (st == ST_DONE);

endmodule

// File: rtl/bytedma_engine.sv
module bytedma_engine
    import bdma_pkg::*;
#(
    parameter int IA_W  = 14,
    parameter int EA_W  = 14,
    parameter int PG_W  = 8,
    parameter int CNT_W = 14,
    parameter int CFG_W = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_addr,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_rdata,
    output logic                 ext_req,
    output logic                 ext_we,
    output logic [EA_W+PG_W-1:0] ext_addr,
    output logic [7:0]           ext_wdata,
    input  logic [7:0]           ext_rdata,
    input  logic                 cpu_ext_req,
    output logic                 mem_en,
    output logic                 mem_we,
    output logic                 mem_pm,
    output logic [IA_W-1:0]      mem_addr,
    output logic [23:0]          mem_wdata,
    input  logic [23:0]          mem_rdata,
    output logic                 irq,
    output logic                 core_hold,
    output logic                 core_restart
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] count;
    logic             start, busy, word_step, byte_step;
    logic             lane_load, lane_push, lane_pop;

    bdma_regs #(
        .IA_W(IA_W), .EA_W(EA_W), .PG_W(PG_W), .CNT_W(CNT_W), .CFG_W(CFG_W)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(cfg_we), .sel(cfg_addr),
        .wr_data(cfg_wdata), .rd_data(cfg_rdata), .busy(busy),
        .word_step(word_step), .byte_step(byte_step), .ctrl(ctrl),
        .iaddr(mem_addr), .xaddr(ext_addr), .count(count), .start(start)
    );

    bdma_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .ctrl(ctrl), .count(count),
        .cpu_ext_req(cpu_ext_req), .busy(busy), .ext_req(ext_req),
        .mem_en(mem_en), .mem_we(mem_we), .word_step(word_step),
        .byte_step(byte_step), .lane_load(lane_load), .lane_push(lane_push),
        .lane_pop(lane_pop), .irq(irq)
    );

    bdma_lane u_lane (
        .clk(clk), .rst(rst), .fmt(ctrl.fmt), .load(lane_load),
        .word_in(mem_rdata), .push(lane_push), .byte_in(ext_rdata),
        .pop(lane_pop), .byte_out(ext_wdata), .word_out(mem_wdata)
    );

    assign ext_we       = ctrl.dir;
    assign mem_pm       = (ctrl.fmt == FMT_PM24);
    assign core_hold    = busy && ctrl.ctx;
    assign core_restart = irq && ctrl.ctx;

endmodule

// File: rtl/bdma_checker.sv
module bdma_checker #(
    parameter int XA_W = 22
) (
    input logic            clk,
    input logic            rst,
    input logic            ext_req,
    input logic            ext_we,
    input logic [XA_W-1:0] ext_addr,
    input logic            cpu_ext_req,
    input logic            mem_en,
    input logic            mem_we,
    input logic            mem_pm,
    input logic [23:0]     mem_wdata,
    input logic            irq,
    input logic            core_hold,
    input logic            core_restart,
    input logic            busy
);
    p_cpu_first_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_req) |-> !$past(cpu_ext_req));

    p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        ext_req && $past(ext_req) |-> $stable(ext_addr) && $stable(ext_we));

    p_zero_fill_r6: assert property (@(posedge clk) disable iff (rst)
        mem_en && mem_we && !mem_pm |-> mem_wdata[23:16] == 8'h00);

    p_irq_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq && !busy);

    p_restart_in_hold_r12: assert property (@(posedge clk) disable iff (rst)
        core_restart |-> irq && core_hold);

    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ext_req && !mem_en);
endmodule

bind bytedma_engine bdma_checker #(.XA_W(EA_W + PG_W)) u_chk (
    .clk(clk), .rst(rst), .ext_req(ext_req), .ext_we(ext_we),
    .ext_addr(ext_addr), .cpu_ext_req(cpu_ext_req), .mem_en(mem_en),
    .mem_we(mem_we), .mem_pm(mem_pm), .mem_wdata(mem_wdata), .irq(irq),
    .core_hold(core_hold), .core_restart(core_restart), .busy(busy)
);

// File: tb/bytedma_engine_bench.sv
`timescale 1ns/1ps
module bytedma_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd4;
    logic [13:0] cfg_wdata = '0;
    logic [13:0] cfg_rdata;
    logic        ext_req, ext_we;
    logic [21:0] ext_addr;
    logic [7:0]  ext_wdata, ext_rdata;
    logic        cpu_ext_req = 1'b0;
    logic        mem_en, mem_we, mem_pm;
    logic [13:0] mem_addr;
    logic [23:0] mem_wdata;
    logic [23:0] mem_rdata = '0;
    logic        irq, core_hold, core_restart;

    bytedma_engine u_bytedma_engine (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ext_req(ext_req),
        .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .ext_rdata(ext_rdata), .cpu_ext_req(cpu_ext_req), .mem_en(mem_en),
        .mem_we(mem_we), .mem_pm(mem_pm), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq),
        .core_hold(core_hold), .core_restart(core_restart)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ext_byte(input logic [21:0] a);
        logic [31:0] t;
        t = {10'b0, a} * 32'd37 + 32'd5;
        return t[7:0] ^ t[15:8];
    endfunction

    function automatic logic [23:0] mem_val(input int a);
        logic [31:0] t;
        t = a * 32'h0001_9E37 + 32'h00A5_5A3C;
        return t[23:0];
    endfunction

    assign ext_rdata = ext_byte(ext_addr);

    // synchronous on-chip memory model: data one cycle after the strobe
    initial forever begin
        @(posedge clk);
        if (mem_en && !mem_we) mem_rdata <= mem_val(int'(mem_addr));
    end

    // processor bus traffic pattern
    bit cpu_mode = 0;
    int cyc = 0;
    initial forever begin
        @(posedge clk);
        #1;
        cyc++;
        cpu_ext_req = cpu_mode && ((cyc % 5) < 2);
    end

    // expectation state
    int          q_xa[$];
    bit          q_xwe[$];
    logic [7:0]  q_xd[$];
    int          q_ma[$];
    logic [23:0] q_md[$];
    int          q_ra[$];
    bit xfer_on = 0, irq_seen = 0, cpu_prev = 0;
    int run = 0, words_done = 0, bytes_done = 0, init_cnt = 0;
    int cur_ws = 0, cur_nb = 1, cur_fmt = 0;
    bit cur_dir = 0, cur_ctx = 0;

    function automatic string fmt_tag(input int f);
        case (f)
            0: return "R4 word fmt0";
            1: return "R5 word fmt1";
            default: return "R6 word fmt2/3";
        endcase
    endfunction

    // cycle monitor, sampled at the falling edge
    initial forever begin
        @(negedge clk);
        if (!rst) begin
            chk(core_hold == (xfer_on && cur_ctx), "R12 hold", core_hold, xfer_on && cur_ctx);
            chk(core_restart == (irq && cur_ctx), "R12 restart", core_restart, irq && cur_ctx);
            if (xfer_on && cfg_addr == 3'd4 && !cfg_we)
                chk(cfg_rdata == 14'(init_cnt - words_done), "R10 live count",
                    cfg_rdata, init_cnt - words_done);
            if (ext_req) begin
                if (!xfer_on || q_xa.size() == 0) begin
                    chk(0, "R2 unexpected byte access", ext_addr, 0);
                end else begin
                    if (run == 0) begin
                        chk(cpu_prev == 0, "R9 processor priority", cpu_prev, 0);
                        chk(ext_addr == 22'(q_xa[0]), "R7 ext address", ext_addr, q_xa[0]);
                        chk(ext_we == q_xwe[0], "R13 ext direction", ext_we, q_xwe[0]);
                        if (ext_we) chk(ext_wdata == q_xd[0], "R13 byte out", ext_wdata, q_xd[0]);
                    end else begin
                        chk(ext_addr == 22'(q_xa[0]), "R8 address held", ext_addr, q_xa[0]);
                    end
                    if (run == cur_ws) begin
                        void'(q_xa.pop_front());
                        void'(q_xwe.pop_front());
                        void'(q_xd.pop_front());
                        run = 0;
                        bytes_done++;
                        if (cur_dir) words_done = bytes_done / cur_nb;
                    end else begin
                        run++;
                    end
                end
            end else if (run != 0) begin
                chk(0, "R8 access too short", run, cur_ws + 1);
                run = 0;
            end
            if (mem_en) begin
                if (!xfer_on) begin
                    chk(0, "R2 unexpected memory access", mem_addr, 0);
                end else if (mem_we) begin
                    if (q_ma.size() == 0) begin
                        chk(0, "R13 extra word write", mem_addr, 0);
                    end else begin
                        chk(mem_addr == 14'(q_ma[0]), "R7 on-chip address", mem_addr, q_ma[0]);
                        chk(mem_wdata == q_md[0], fmt_tag(cur_fmt), mem_wdata, q_md[0]);
                        chk(mem_pm == (cur_fmt == 0), "R4 memory space", mem_pm, cur_fmt == 0);
                        void'(q_ma.pop_front());
                        void'(q_md.pop_front());
                        words_done++;
                    end
                end else begin
                    if (q_ra.size() == 0) begin
                        chk(0, "R13 extra word read", mem_addr, 0);
                    end else begin
                        chk(mem_addr == 14'(q_ra[0]), "R13 read address", mem_addr, q_ra[0]);
                        void'(q_ra.pop_front());
                    end
                end
            end
            if (irq) begin
                chk(xfer_on, "R11 irq only at end", 0, 1);
                chk(q_xa.size() + q_ma.size() + q_ra.size() == 0, "R11 all moved",
                    q_xa.size() + q_ma.size() + q_ra.size(), 0);
                xfer_on = 0;
                irq_seen = 1;
            end
            cpu_prev = cpu_ext_req;
        end
    end

    task automatic cfg_write(input int a, input int d);
        @(posedge clk);
        #1;
        cfg_we = 1;
        cfg_addr = 3'(a);
        cfg_wdata = 14'(d);
        @(posedge clk);
        #1;
        cfg_we = 0;
        cfg_addr = 3'd4;
        if (a == 4 && d != 0 && !xfer_on) begin
            xfer_on = 1;
            irq_seen = 0;
            init_cnt = d;
            words_done = 0;
            bytes_done = 0;
            run = 0;
        end
    endtask

    task automatic cfg_read(input int a, output int v);
        @(posedge clk);
        #1;
        cfg_addr = 3'(a);
        @(negedge clk);
        v = int'(cfg_rdata);
    endtask

    task automatic start_xfer(input bit dir, input int fmt, input int ws, input bit ctx,
                              input int ia, input int pg, input int eo, input int cnt);
        int ea;
        logic [7:0] b [3];
        logic [23:0] w;
        cur_dir = dir; cur_fmt = fmt; cur_ws = ws; cur_ctx = ctx;
        cur_nb = (fmt == 0) ? 3 : (fmt == 1) ? 2 : 1;
        ea = (pg << 14) | eo;
        for (int n = 0; n < cnt; n++) begin
            if (!dir) begin
                for (int k = 0; k < cur_nb; k++) begin
                    b[k] = ext_byte(22'(ea));
                    q_xa.push_back(ea); q_xwe.push_back(0); q_xd.push_back(8'h00);
                    ea = (ea + 1) & 32'h3F_FFFF;
                end
                case (fmt)
                    0: w = {b[0], b[1], b[2]};
                    1: w = {8'h00, b[0], b[1]};
                    2: w = {8'h00, b[0], 8'h00};
                    default: w = {16'h0000, b[0]};
                endcase
                q_ma.push_back((ia + n) & 32'h3FFF);
                q_md.push_back(w);
            end else begin
                q_ra.push_back((ia + n) & 32'h3FFF);
                w = mem_val((ia + n) & 32'h3FFF);
                case (fmt)
                    0: begin b[0] = w[23:16]; b[1] = w[15:8]; b[2] = w[7:0]; end
                    1: begin b[0] = w[15:8]; b[1] = w[7:0]; end
                    2: b[0] = w[15:8];
                    default: b[0] = w[7:0];
                endcase
                for (int k = 0; k < cur_nb; k++) begin
                    q_xa.push_back(ea); q_xwe.push_back(1); q_xd.push_back(b[k]);
                    ea = (ea + 1) & 32'h3F_FFFF;
                end
            end
        end
        cfg_write(0, (int'(ctx) << 7) | (ws << 3) | (fmt << 1) | int'(dir));
        cfg_write(1, ia);
        cfg_write(2, eo);
        cfg_write(3, pg);
        cfg_write(4, cnt);
    endtask

    task automatic finish_xfer(input int ia, input int pg, input int eo, input int cnt);
        int v, ea;
        while (!irq_seen) @(negedge clk);
        ea = (((pg << 14) | eo) + cnt * cur_nb) & 32'h3F_FFFF;
        cfg_read(4, v); chk(v == 0, "R11 count zero after irq", v, 0);
        cfg_read(1, v); chk(v == ((ia + cnt) & 32'h3FFF), "R7 on-chip address advanced", v, (ia + cnt) & 32'h3FFF);
        cfg_read(2, v); chk(v == (ea & 32'h3FFF), "R7 offset advanced", v, ea & 32'h3FFF);
        cfg_read(3, v); chk(v == (ea >> 14), "R7 page carry", v, ea >> 14);
        cfg_addr = 3'd4;
    endtask

    task automatic xfer(input bit dir, input int fmt, input int ws, input bit ctx,
                        input int ia, input int pg, input int eo, input int cnt);
        start_xfer(dir, fmt, ws, ctx, ia, pg, eo, cnt);
        finish_xfer(ia, pg, eo, cnt);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (4) @(posedge clk);
        #1 rst = 0;

        // R1: reset values
        for (int a = 0; a < 5; a++) begin
            cfg_read(a, v);
            chk(v == 0, "R1 reset value", v, 0);
        end
        chk(!ext_req && !mem_en && !irq && !core_hold, "R1 outputs after reset",
            {ext_req, mem_en, irq, core_hold}, 0);

        // R1: readback and field widths
        cfg_write(0, 8'hD5);   cfg_read(0, v); chk(v == 8'hD5, "R1 control readback", v, 8'hD5);
        cfg_write(1, 14'h2ABC); cfg_read(1, v); chk(v == 14'h2ABC, "R1 on-chip address readback", v, 14'h2ABC);
        cfg_write(2, 14'h1234); cfg_read(2, v); chk(v == 14'h1234, "R1 offset readback", v, 14'h1234);
        cfg_write(3, 14'h3FA7); cfg_read(3, v); chk(v == 8'hA7, "R1 page width", v, 8'hA7);

        // R2: zero count starts nothing
        cfg_write(4, 0);
        repeat (12) @(negedge clk);
        chk(!ext_req && !mem_en && !irq, "R2 zero count idle", {ext_req, mem_en, irq}, 0);
        cfg_read(4, v); chk(v == 0, "R2 zero count value", v, 0);

        // R4 with page carry (R7)
        xfer(0, 0, 0, 0, 14'h0010, 5, 14'h3FFE, 3);
        // R5 with wait states (R8) and bus contention (R9)
        cpu_mode = 1;
        xfer(0, 1, 2, 0, 14'h0100, 1, 14'h0020, 4);
        cpu_mode = 0;
        // R6 both byte placements
        xfer(0, 2, 1, 0, 14'h3FFF, 2, 14'h0100, 2);
        xfer(0, 3, 0, 0, 14'h0200, 0, 14'h0000, 3);
        // R13 outbound with core restart (R12)
        xfer(1, 0, 3, 1, 14'h0040, 7, 14'h0300, 2);
        cpu_mode = 1;
        xfer(1, 3, 0, 0, 14'h0050, 3, 14'h0011, 3);
        cpu_mode = 0;
        xfer(1, 1, 1, 1, 14'h0060, 8'hFF, 14'h3FFF, 1);
        xfer(1, 2, 0, 0, 14'h0070, 4, 14'h0005, 2);

        // R3: writes during a transfer are ignored
        start_xfer(0, 0, 5, 0, 14'h0300, 9, 14'h0400, 2);
        repeat (4) @(negedge clk);
        cfg_write(1, 14'h0123);
        cfg_write(4, 100);
        cfg_write(0, 8'h80);
        cfg_write(3, 8'h11);
        finish_xfer(14'h0300, 9, 14'h0400, 2);
        cfg_read(0, v); chk(v == (5 << 3), "R3 control untouched", v, 5 << 3);

        repeat (5) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule